// File: doc/BRIEF.md
# Protected-Configuration Watchdog Timer

This block is a watchdog timer clocked by a slow oscillator. The oscillator is modelled as a single-cycle tick enable in the system clock domain. A free-running prescaler counts ticks while the watchdog is enabled. A 4-bit period code picks one of ten tap lengths, each twice as long as the one before. When the count expires, the block does one of two things. If the interrupt enable bit is clear, it drives a one-cycle system reset pulse. If the interrupt enable bit is set, it sets a sticky interrupt flag, which lets the timer wake a sleeping system instead of resetting it. Software stops a time-out by pulsing the kick input.

Configuration goes through a small write port with two addresses: a control register and an unlock key register. A static fuse input picks one of two protection levels.
- At the low level the watchdog starts disabled. It may be enabled at any time and its period may be changed freely. Turning it off needs the unlock key first.
- At the high level the watchdog is always on. A period change needs the unlock key first.

A correct key opens a short window. The window closes after one protected write has been accepted, or when the window runs out, whichever comes first.

The write port, the kick input and the fuse are plain control pins, with no handshake. Every write completes in the cycle it is presented.

Top module: `wdt_guard`

## Requirements
- R1: After reset, with the fuse low, the control readback `ctrl_rd` is 8'h00, and `sys_rst_o` and `irq_o` are low. With the fuse high it reads 8'h10 (enable bit 4 set, period code 0). The readback layout is: bits 3:0 period code, bit 4 enable, bit 5 interrupt enable, bit 6 interrupt flag, bit 7 zero.
- R2: While enabled, a time-out occurs after every 2^(MIN_LOG2+code) oscillator ticks, for codes 0 to 9. Only cycles with `osc_tick` high advance the count.
- R3: Codes 10 to 15 give the same period as code 9, and they read back as written.
- R4: With interrupt enable low, each time-out produces a `sys_rst_o` pulse exactly one cycle wide, and the count starts again from zero.
- R5: With interrupt enable high, a time-out sets the flag (bit 6) and no reset is produced. `irq_o` equals flag AND interrupt enable. Writing 1 to bit 6 clears the flag.
- R6: A `kick` pulse, or an accepted write that changes the period code, restarts the count from zero.
- R7: At the low level, a control write may set the enable bit or change the period at any time, without a key.
- R8: At the low level, a write that would clear a set enable bit takes effect only while the unlock window is open. Otherwise the enable bit stays 1, while the rest of the write still applies.
- R9: At the high level, the enable bit reads 1 whatever is written. A period change is accepted only while the window is open.
- R10: The window opens only when KEY is written to address 1, and covers the next 4 cycles. A wrong value does not open it. The window closes after one accepted protected write: a low-level disable, or a high-level period change.
- R11: While disabled, no time-out, reset pulse or flag occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fuse_lvl2 | input | 1 | Protection level select, static: 0 low level, 1 high level |
| osc_tick | input | 1 | One-cycle enable per slow oscillator period |
| kick | input | 1 | Restart the time-out count |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 control register, 1 unlock key register |
| wr_data | input | 8 | Write data |
| ctrl_rd | output | 8 | Control register readback |
| irq_o | output | 1 | Interrupt request |
| sys_rst_o | output | 1 | One-cycle system reset pulse |

## Verification
The assertions rely on four things about the inputs:
- `fuse_lvl2` changes only while reset is held.
- MIN_LOG2 is at least 1, so two time-outs can never fall on adjacent cycles.
- A key write and a control write never arrive in the same cycle, because the port has a single address.
- A protected write is presented as one strobe.

The bench follows all four. It changes the fuse only inside its reset task, and it runs with MIN_LOG2 set to 2. Every write is a single-cycle strobe driven at the falling edge, and the key and the control write always go in separate cycles.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam logic ADDR_CTRL = 1'b0;
  localparam logic ADDR_KEY  = 1'b1;

  localparam int BIT_EN   = 4;
  localparam int BIT_IE   = 5;
  localparam int BIT_FLAG = 6;

  typedef struct packed {
    logic       flag;
    logic       ie;
    logic       en;
    logic [3:0] per;
  } wdt_ctrl_t;
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int MIN_LOG2 = 11,
  parameter int NUM_TAPS = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       run,
  input  logic       clear,
  input  logic [3:0] sel,
  output logic       expire
);
  localparam int CW = MIN_LOG2 + NUM_TAPS - 1;

  logic [CW-1:0] count;
  logic [CW-1:0] limit;
  logic [3:0]    sel_eff;
  logic [CW-1:0] tap_lim [NUM_TAPS];

  // one terminal count per tap, each twice the previous length
  for (genvar g = 0; g < NUM_TAPS; g++) begin : g_tap
    assign tap_lim[g] = {CW{1'b1}} >> (NUM_TAPS - 1 - g);
  end

  // reserved codes saturate to the longest tap
  assign sel_eff = (32'(sel) >= NUM_TAPS) ? 4'(NUM_TAPS - 1) : sel;

  always_comb begin
    limit = '0;
    for (int i = 0; i < NUM_TAPS; i++)
      if (sel_eff == 4'(i)) limit = tap_lim[i];
  end

  assign expire = run && tick && !clear && (count == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               count <= '0;
    else if (clear || !run)   count <= '0;
    else if (tick)            count <= (count == limit) ? '0 : count + 1'b1;
  end

  // the top clears the count whenever the code changes, so it never overshoots the tap
  assert_count_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    count <= limit);
  assert_idle_holds_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (count == '0));
endmodule

// File: rtl/wdt_unlock.sv
module wdt_unlock #(
  parameter logic [7:0] KEY    = 8'hC5,
  parameter int         WINDOW = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       key_wr,
  input  logic [7:0] key_val,
  input  logic       consume,
  output logic       open_o
);
  localparam int CNT_W = $clog2(WINDOW + 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (key_wr)         cnt <= (key_val == KEY) ? CNT_W'(WINDOW) : '0;
    else if (consume)        cnt <= '0;
    else if (cnt != '0)      cnt <= cnt - 1'b1;
  end

  assign open_o = (cnt != '0);

  assert_consume_closes_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (consume && !key_wr) |=> !open_o);
  assert_bad_key_closed_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (key_wr && key_val != KEY) |=> !open_o);
  assert_consume_needs_open_R10: assert property (@(posedge clk) disable iff (!rst_n)
    consume |-> open_o);
endmodule

// File: rtl/wdt_guard.sv
module wdt_guard #(
  parameter int         MIN_LOG2 = 11,
  parameter int         NUM_TAPS = 10,
  parameter logic [7:0] KEY      = 8'hC5,
  parameter int         WINDOW   = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fuse_lvl2,
  input  logic       osc_tick,
  input  logic       kick,
  input  logic       wr_en,
  input  logic       wr_addr,
  input  logic [7:0] wr_data,
  output logic [7:0] ctrl_rd,
  output logic       irq_o,
  output logic       sys_rst_o
);
  import wdt_pkg::*;

  wdt_ctrl_t  cfg;
  logic       en_eff, win_open, expire;
  logic       ctrl_wr, key_wr, per_change, disabling;
  logic       en_ok, per_ok, consume, restart;
  logic [3:0] w_per;

  assign ctrl_wr = wr_en && (wr_addr == ADDR_CTRL);
  assign key_wr  = wr_en && (wr_addr == ADDR_KEY);
  assign w_per   = wr_data[3:0];

  assign en_eff     = fuse_lvl2 || cfg.en;
  assign per_change = (w_per != cfg.per);
  assign disabling  = cfg.en && !wr_data[BIT_EN];

  // protection gate: which parts of a control write may land
  always_comb begin
    if (fuse_lvl2) begin
      en_ok   = 1'b0;
      per_ok  = !per_change || win_open;
      consume = ctrl_wr && per_change && win_open;
    end else begin
      en_ok   = !disabling || win_open;
      per_ok  = 1'b1;
      consume = ctrl_wr && disabling && win_open;
    end
  end

  assign restart = kick || (ctrl_wr && per_ok && per_change);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg       <= '0;
      sys_rst_o <= 1'b0;
    end else begin
      sys_rst_o <= expire && !cfg.ie;
      if (ctrl_wr) begin
        cfg.ie <= wr_data[BIT_IE];
        if (en_ok)  cfg.en  <= wr_data[BIT_EN];
        if (per_ok) cfg.per <= w_per;
      end
      if (expire && cfg.ie)                   cfg.flag <= 1'b1;
      else if (ctrl_wr && wr_data[BIT_FLAG])  cfg.flag <= 1'b0;
    end
  end

  wdt_unlock #(.KEY(KEY), .WINDOW(WINDOW)) u_unlock (
    .clk     (clk),
    .rst_n   (rst_n),
    .key_wr  (key_wr),
    .key_val (wr_data),
    .consume (consume),
    .open_o  (win_open)
  );

  wdt_prescaler #(.MIN_LOG2(MIN_LOG2), .NUM_TAPS(NUM_TAPS)) u_presc (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (osc_tick),
    .run    (en_eff),
    .clear  (restart),
    .sel    (cfg.per),
    .expire (expire)
  );

  assign ctrl_rd = {1'b0, cfg.flag, cfg.ie, en_eff, cfg.per};
  assign irq_o   = cfg.flag && cfg.ie;

  // relies on MIN_LOG2 >= 1 so time-outs are never back to back
  assert_rst_one_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_o |=> !sys_rst_o);
  assert_lvl2_enabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fuse_lvl2 |-> ctrl_rd[BIT_EN]);
  assert_irq_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ctrl_rd[BIT_IE]);
  assert_no_rst_when_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_rd[BIT_EN] |=> !sys_rst_o);
  assert_locked_disable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!fuse_lvl2 && ctrl_wr && disabling && !win_open) |=> ctrl_rd[BIT_EN]);
  assert_locked_period_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fuse_lvl2 && ctrl_wr && !win_open) |=> $stable(ctrl_rd[3:0]));
endmodule

// File: tb/wdt_guard_tb_top.sv
`timescale 1ns/1ps
module wdt_guard_tb_top;
  localparam logic [7:0] KEY = 8'hC5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fuse_lvl2 = 1'b0;
  logic       osc_tick = 1'b1;
  logic       kick = 1'b0;
  logic       wr_en = 1'b0;
  logic       wr_addr = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] ctrl_rd;
  logic       irq_o, sys_rst_o;
  logic       slow_tick = 1'b0;
  int         errors = 0;
  int         checks = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  always @(negedge clk) osc_tick <= slow_tick ? ~osc_tick : 1'b1;

  wdt_guard #(.MIN_LOG2(2), .NUM_TAPS(10), .KEY(KEY), .WINDOW(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .fuse_lvl2(fuse_lvl2), .osc_tick(osc_tick),
    .kick(kick), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ctrl_rd(ctrl_rd), .irq_o(irq_o), .sys_rst_o(sys_rst_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input logic lvl);
    @(negedge clk);
    rst_n = 1'b0;
    fuse_lvl2 = lvl;
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_pulse(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!sys_rst_o && n < 6000);
  endtask

  task automatic count_pulses(input int cycles, output int p);
    p = 0;
    repeat (cycles) begin
      @(negedge clk);
      if (sys_rst_o) p++;
    end
  endtask

  task automatic t_reset_lvl1;
    int p;
    do_reset(1'b0);
    chk("R1 ctrl_rd lvl1", ctrl_rd, 8'h00);
    chk("R1 sys_rst_o", sys_rst_o, 0);
    chk("R1 irq_o", irq_o, 0);
    count_pulses(80, p);
    chk("R11 no pulse while disabled", p, 0);
  endtask

  task automatic t_periods;
    int n;
    wr(1'b0, 8'h10);
    chk("R7 enable without key", ctrl_rd, 8'h10);
    wait_pulse(n);
    wait_pulse(n);
    chk("R2 code0 interval", n, 4);
    @(negedge clk);
    chk("R4 pulse one cycle", sys_rst_o, 0);
    wr(1'b0, 8'h13);
    wait_pulse(n);
    chk("R6 period write restarts", n, 32);
    wait_pulse(n);
    chk("R2 code3 interval", n, 32);
    wr(1'b0, 8'h19);
    wait_pulse(n);
    wait_pulse(n);
    chk("R2 code9 interval", n, 2048);
    wr(1'b0, 8'h1C);
    chk("R3 reserved readback", ctrl_rd[3:0], 4'hC);
    wait_pulse(n);
    wait_pulse(n);
    chk("R3 reserved code interval", n, 2048);
  endtask

  task automatic t_slow_tick;
    int n;
    wr(1'b0, 8'h13);
    slow_tick = 1'b1;
    wait_pulse(n);
    wait_pulse(n);
    chk("R2 half-rate tick interval", n, 64);
    slow_tick = 1'b0;
    idle(2);
  endtask

  task automatic t_kick;
    int n;
    wait_pulse(n);
    idle(10);
    kick = 1'b1;
    @(negedge clk);
    kick = 1'b0;
    wait_pulse(n);
    chk("R6 kick restarts count", n, 32);
  endtask

  task automatic t_irq;
    int p;
    wr(1'b0, 8'h30);
    count_pulses(12, p);
    chk("R5 no reset in irq mode", p, 0);
    chk("R5 flag set", ctrl_rd[6], 1);
    chk("R5 irq_o raised", irq_o, 1);
    wr(1'b0, 8'h39);
    wr(1'b0, 8'h79);
    chk("R5 flag cleared by W1C", ctrl_rd[6], 0);
    chk("R5 irq_o dropped", irq_o, 0);
    wr(1'b0, 8'h19);
    chk("R5 irq disabled readback", ctrl_rd, 8'h19);
  endtask

  task automatic t_lvl1_protect;
    int p;
    wr(1'b0, 8'h09);
    chk("R8 disable blocked without key", ctrl_rd[4], 1);
    wr(1'b0, 8'h15);
    chk("R7 free period change", ctrl_rd, 8'h15);
    wr(1'b1, KEY);
    wr(1'b0, 8'h00);
    chk("R8 disable with key", ctrl_rd, 8'h00);
    count_pulses(40, p);
    chk("R11 no pulse after disable", p, 0);
  endtask

  task automatic t_window;
    wr(1'b0, 8'h10);
    wr(1'b1, KEY ^ 8'h01);
    wr(1'b0, 8'h00);
    chk("R10 wrong key keeps lock", ctrl_rd[4], 1);
    wr(1'b1, KEY);
    idle(4);
    wr(1'b0, 8'h00);
    chk("R10 window expired", ctrl_rd[4], 1);
    wr(1'b1, KEY);
    idle(3);
    wr(1'b0, 8'h00);
    chk("R10 last window cycle accepted", ctrl_rd[4], 0);
    wr(1'b0, 8'h10);
    wr(1'b1, KEY);
    wr(1'b0, 8'h00);
    wr(1'b0, 8'h10);
    wr(1'b0, 8'h00);
    chk("R10 window consumed by one write", ctrl_rd[4], 1);
  endtask

  task automatic t_lvl2;
    int n;
    do_reset(1'b1);
    chk("R1 ctrl_rd lvl2", ctrl_rd, 8'h10);
    wait_pulse(n);
    wait_pulse(n);
    chk("R9 runs from reset", n, 4);
    wr(1'b0, 8'h03);
    chk("R9 period locked", ctrl_rd, 8'h10);
    wr(1'b1, KEY);
    wr(1'b0, 8'h03);
    chk("R9 keyed period change, enable ignored", ctrl_rd, 8'h13);
    wr(1'b0, 8'h05);
    chk("R10 lvl2 window consumed", ctrl_rd, 8'h13);
    wait_pulse(n);
    wait_pulse(n);
    chk("R9 new period active", n, 32);
  endtask

  initial begin
    t_reset_lvl1();
    t_periods();
    t_slow_tick();
    t_kick();
    t_irq();
    t_lvl1_protect();
    t_window();
    t_lvl2();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule